// File: doc/BRIEF.md
# Pushbutton Power Control Sequencer

This block watches one active-low pushbutton and turns the length of each hold into a power decision for a regulator system. When the system is off, a long enough hold raises a wake output. That output can enable the first regulator of a power-up chain. While the system is on, any press that passes a shorter threshold is shown on a status output for as long as the button stays down. A very long hold while the system is on forces a hard shutdown. The shutdown drops the wake output, raises a global regulator-disable output, and drives an active-low reset output for a fixed time. It also starts a lockout window in which the button is ignored.

All durations are counted in units of a one-cycle `tick_i` strobe, nominally 1 ms. A bench can shorten real time by pulsing the tick more often. The raw button passes through a two-flop synchronizer before any counting. Every threshold is measured on the synchronized, continuous press: a release restarts the count from zero.

Top module: `pb_power_seq`

## Requirements
- R1: After reset, `wake_o` and `pbstat_o` are 0, `reg_off_o` is 0 and `rst_no` is 1.
- R2: While off, once the synchronized press has lasted WAKE_MS ticks without a break, `wake_o` goes to 1 on the next clock and stays 1 after the button is released.
- R3: A release before any threshold restarts the hold count from zero, so two holds of WAKE_MS-1 ticks separated by a release do not wake the system.
- R4: While on, `pbstat_o` is 1 exactly while the current press has lasted at least MIRROR_MS ticks. It returns to 0 within three clocks of the button input going high. The count includes the press that woke the system.
- R5: While on, a continuous hold of HARD_MS ticks, counted from the start of the press, sets `wake_o` to 0 and `reg_off_o` to 1. The hold count never exceeds HARD_MS.
- R6: From the hard shutdown, `rst_no` is 0 for RST_MS ticks and then returns to 1, where RST_MS <= LOCK_MS.
- R7: For LOCK_MS ticks after the hard shutdown, `reg_off_o` stays 1 and the button has no effect: a press longer than WAKE_MS gives neither `wake_o` nor `pbstat_o`.
- R8: When the lockout ends, `reg_off_o` returns to 0 and the system is off with `wake_o` 0. If the button is still held, it must be released before a new WAKE_MS hold is counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | One-cycle time-base strobe (one unit of duration) |
| btn_ni | input | 1 | Raw pushbutton, low while pressed |
| wake_o | output | 1 | High while the system is powered on |
| pbstat_o | output | 1 | High while a qualified press is held in the on state |
| rst_no | output | 1 | Low during the hard-shutdown reset pulse |
| reg_off_o | output | 1 | High while all regulators are forced off (lockout) |

## Verification
Two events can fall in the same cycle: the lockout counter expiring and the button still being held. The block must then go to a release-wait state, not to a fresh wake. The bench provokes this by holding the button through the whole lockout and past another WAKE_MS ticks. It then checks that `wake_o` stays low until a release and a new full hold. The second collision is the tick on which the hold count reaches HARD_MS while `pbstat_o` is high. The bench judges it by checking that `pbstat_o` and `wake_o` fall together as `reg_off_o` rises.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic [1:0] {
    PB_OFF     = 2'd0,
    PB_ON      = 2'd1,
    PB_LOCK    = 2'd2,
    PB_WAITREL = 2'd3
  } pb_state_e;
endpackage

// File: rtl/pb_sync.sv
module pb_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pb_hold_timer.sv
module pb_hold_timer #(
  parameter int MAX_CNT = 5000,
  localparam int W = $clog2(MAX_CNT + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pressed_i,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i | ~pressed_i | tick_i;
    cnt_d  = cnt_q;
    if (clr_i || !pressed_i) begin
      cnt_d = '0;
    end else if (tick_i && (cnt_q != W'(MAX_CNT))) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pb_ctrl_fsm.sv
module pb_ctrl_fsm
  import pb_pkg::*;
#(
  parameter int WAKE_MS   = 400,
  parameter int MIRROR_MS = 50,
  parameter int HARD_MS   = 5000,
  parameter int RST_MS    = 1000,
  parameter int LOCK_MS   = 1000,
  localparam int HOLD_W   = $clog2(HARD_MS + 1),
  localparam int LOCK_W   = $clog2(LOCK_MS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pressed_i,
  input  logic [HOLD_W-1:0] hold_cnt_i,
  output logic              hold_clr_o,
  output logic              wake_o,
  output logic              pbstat_o,
  output logic              rst_no,
  output logic              reg_off_o
);
  pb_state_e         state_q, state_d;
  logic [LOCK_W-1:0] lock_q, lock_d;
  logic              lock_en;

  always_comb begin
    state_d = state_q;
    lock_d  = lock_q;
    lock_en = 1'b0;
    unique case (state_q)
      PB_OFF: begin
        if (hold_cnt_i >= HOLD_W'(WAKE_MS)) state_d = PB_ON;
      end
      PB_ON: begin
        if (hold_cnt_i >= HOLD_W'(HARD_MS)) begin
          state_d = PB_LOCK;
          lock_d  = '0;
          lock_en = 1'b1;
        end
      end
      PB_LOCK: begin
        if (tick_i) begin
          if (lock_q == LOCK_W'(LOCK_MS - 1)) begin
            state_d = pressed_i ? PB_WAITREL : PB_OFF;
          end else begin
            lock_d  = lock_q + 1'b1;
            lock_en = 1'b1;
          end
        end
      end
      PB_WAITREL: begin
        if (!pressed_i) state_d = PB_OFF;
      end
      default: state_d = PB_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PB_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  assign hold_clr_o = (state_q == PB_LOCK) || (state_q == PB_WAITREL);
  assign wake_o     = (state_q == PB_ON);
  assign pbstat_o   = (state_q == PB_ON) && (hold_cnt_i >= HOLD_W'(MIRROR_MS));
  assign reg_off_o  = (state_q == PB_LOCK);
  assign rst_no     = !((state_q == PB_LOCK) && (lock_q < LOCK_W'(RST_MS)));
endmodule

// File: rtl/pb_power_seq.sv
module pb_power_seq #(
  parameter int WAKE_MS   = 400,
  parameter int MIRROR_MS = 50,
  parameter int HARD_MS   = 5000,
  parameter int RST_MS    = 1000,
  parameter int LOCK_MS   = 1000,
  localparam int HOLD_W   = $clog2(HARD_MS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic btn_ni,
  output logic wake_o,
  output logic pbstat_o,
  output logic rst_no,
  output logic reg_off_o
);
  logic              btn_sync_n;
  logic              pressed;
  logic              hold_clr;
  logic [HOLD_W-1:0] hold_cnt;

  pb_sync #(.RST_VAL(1'b1)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (btn_ni),
    .q_o    (btn_sync_n)
  );

  assign pressed = ~btn_sync_n;

  pb_hold_timer #(.MAX_CNT(HARD_MS)) hold_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pressed_i (pressed),
    .clr_i     (hold_clr),
    .tick_i    (tick_i),
    .cnt_o     (hold_cnt)
  );

  pb_ctrl_fsm #(
    .WAKE_MS   (WAKE_MS),
    .MIRROR_MS (MIRROR_MS),
    .HARD_MS   (HARD_MS),
    .RST_MS    (RST_MS),
    .LOCK_MS   (LOCK_MS)
  ) fsm_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .pressed_i  (pressed),
    .hold_cnt_i (hold_cnt),
    .hold_clr_o (hold_clr),
    .wake_o     (wake_o),
    .pbstat_o   (pbstat_o),
    .rst_no     (rst_no),
    .reg_off_o  (reg_off_o)
  );
endmodule

// File: rtl/pb_power_seq_chk.sv
module pb_power_seq_chk #(
  parameter int HOLD_W  = 13,
  parameter int HARD_MS = 5000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pressed_i,
  input logic [HOLD_W-1:0] hold_cnt_i,
  input logic              wake_o,
  input logic              pbstat_o,
  input logic              rst_no,
  input logic              reg_off_o
);
  a_r2_wake_needs_press: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(pressed_i));

  a_r4_pbstat_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pressed_i |=> !pbstat_o);

  a_r5_hard_from_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_off_o) |-> $past(wake_o));

  a_r5_hold_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_cnt_i <= HOLD_W'(HARD_MS));

  a_r6_rst_only_in_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_no |-> reg_off_o);

  a_r7_lock_clears_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_off_o && $past(reg_off_o)) |-> (hold_cnt_i == '0));

  a_r8_exit_to_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reg_off_o) |-> !wake_o);
endmodule

bind pb_power_seq pb_power_seq_chk #(
  .HOLD_W  (HOLD_W),
  .HARD_MS (HARD_MS)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pressed_i  (pressed),
  .hold_cnt_i (hold_cnt),
  .wake_o     (wake_o),
  .pbstat_o   (pbstat_o),
  .rst_no     (rst_no),
  .reg_off_o  (reg_off_o)
);

// File: tb/pb_power_seq_tb_top.sv
module pb_power_seq_tb_top;
  localparam int WAKE   = 400;
  localparam int MIRROR = 50;
  localparam int HARD   = 5000;
  localparam int RSTP   = 600;
  localparam int LOCK   = 1000;

  logic clk = 1'b0;
  logic rst_ni, tick_i, btn_ni;
  logic wake_o, pbstat_o, rst_no, reg_off_o;
  int   total = 0;
  int   bad   = 0;

  always #2.5 clk = ~clk;

  pb_power_seq #(
    .WAKE_MS(WAKE), .MIRROR_MS(MIRROR), .HARD_MS(HARD),
    .RST_MS(RSTP), .LOCK_MS(LOCK)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .btn_ni(btn_ni),
    .wake_o(wake_o), .pbstat_o(pbstat_o), .rst_no(rst_no), .reg_off_o(reg_off_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic press();
    btn_ni = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic release_btn();
    btn_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 wake", wake_o, 1'b0);
    chk("R1 pbstat", pbstat_o, 1'b0);
    chk("R1 rst_no", rst_no, 1'b1);
    chk("R1 reg_off", reg_off_o, 1'b0);
  endtask

  task automatic t_wake();
    press(); ticks(WAKE - 1);
    chk("R2 no wake before threshold", wake_o, 1'b0);
    release_btn();
    press(); ticks(WAKE - 1);
    chk("R3 count restarted after release", wake_o, 1'b0);
    ticks(1);
    chk("R2 wake at threshold", wake_o, 1'b1);
    chk("R4 pbstat on waking press", pbstat_o, 1'b1);
    release_btn();
    chk("R2 wake held after release", wake_o, 1'b1);
    chk("R4 pbstat off after release", pbstat_o, 1'b0);
  endtask

  task automatic t_mirror();
    press(); ticks(MIRROR - 1);
    chk("R4 pbstat below threshold", pbstat_o, 1'b0);
    ticks(1);
    chk("R4 pbstat at threshold", pbstat_o, 1'b1);
    ticks(20);
    chk("R4 pbstat while held", pbstat_o, 1'b1);
    release_btn();
    chk("R4 pbstat released", pbstat_o, 1'b0);
    chk("R4 wake unchanged", wake_o, 1'b1);
  endtask

  task automatic t_hard_held();
    press(); ticks(HARD - 1);
    chk("R5 still on before hard", wake_o, 1'b1);
    chk("R5 pbstat before hard", pbstat_o, 1'b1);
    chk("R5 reg_off before hard", reg_off_o, 1'b0);
    ticks(1);
    chk("R5 wake dropped", wake_o, 1'b0);
    chk("R5 pbstat dropped", pbstat_o, 1'b0);
    chk("R5 reg_off raised", reg_off_o, 1'b1);
    chk("R6 rst_no low", rst_no, 1'b0);
    ticks(RSTP - 1);
    chk("R6 rst_no still low", rst_no, 1'b0);
    ticks(1);
    chk("R6 rst_no released", rst_no, 1'b1);
    chk("R7 reg_off in lockout", reg_off_o, 1'b1);
    ticks(LOCK - RSTP - 1);
    chk("R7 reg_off last lock tick", reg_off_o, 1'b1);
    chk("R7 no wake in lock", wake_o, 1'b0);
    ticks(1);
    chk("R8 reg_off cleared", reg_off_o, 1'b0);
    chk("R8 off after lock", wake_o, 1'b0);
    ticks(WAKE + 100);
    chk("R8 held button needs release", wake_o, 1'b0);
    release_btn();
    press(); ticks(WAKE);
    chk("R8 new hold wakes", wake_o, 1'b1);
    release_btn();
  endtask

  task automatic t_lock_ignore();
    press(); ticks(HARD);
    chk("R5 second hard", reg_off_o, 1'b1);
    release_btn();
    press(); ticks(WAKE + 50);
    chk("R7 press ignored wake", wake_o, 1'b0);
    chk("R7 press ignored pbstat", pbstat_o, 1'b0);
    chk("R7 still locked", reg_off_o, 1'b1);
    release_btn();
    ticks(LOCK - WAKE - 50);
    chk("R8 lock ended", reg_off_o, 1'b0);
    chk("R8 off", wake_o, 1'b0);
    press(); ticks(WAKE);
    chk("R8 wake after lock", wake_o, 1'b1);
    release_btn();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; tick_i = 1'b0; btn_ni = 1'b1;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_wake();
    t_mirror();
    t_hard_held();
    t_lock_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule